// File: doc/BRIEF.md
# Radix-4 Booth Multiplier with Redundant Two-Bus Result

This block multiplies two operands of parameterised width without resolving the product. The multiplier operand is recoded into signed radix-4 digits. Each digit picks zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. These partial products are compressed by rows of 3:2 carry-save adders until two vectors remain. No final carry-propagate adder is built. The block therefore delivers two buses, each `A_W+B_W` bits wide, and their sum modulo `2^(A_W+B_W)` is the product.

The intended use is inside a larger summation. A following multi-operand adder takes both buses as two of its inputs and absorbs the product at the cost of two extra rows, not a full-width carry chain. One parameter makes both operands two's complement or both unsigned. The multiplicand must be at least as wide as the multiplier, and each width must be at least 2. The block is purely combinational and holds no state.

Top module: `booth_csa_mul`

## Requirements
- R1: For every input pair, `(psum_o + pcarry_o) mod 2^(A_W+B_W)` equals the product of `op_a_i` and `op_b_i` in the selected representation.
- R2: Bit 0 of `pcarry_o` is 0 for every input.
- R3: With `SIGNED_OPS=1`, both operands are two's complement (an MSB of 1 is negative). With `SIGNED_OPS=0`, both are unsigned.
- R4: Each radix-4 digit selects at most one magnitude: either the single multiple or the double multiple, never both.
- R5: A zero digit never asserts negation. This covers the groups 000 and 111 of the multiplier.
- R6: In unsigned mode, the multiplier is zero-extended so that the most significant digit is never negative.
- R7: In signed mode, the most negative multiplicand times the most negative multiplier gives exactly `2^(A_W+B_W-2)`. In unsigned mode, all-ones times all-ones gives `(2^A_W-1)(2^B_W-1)`.
- R8: The outputs depend only on the present inputs. No clock edge is needed between an input change and a settled result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | A_W | Multiplicand |
| op_b_i | input | B_W | Multiplier, Booth-recoded |
| psum_o | output | A_W+B_W | Sum vector of the redundant product |
| pcarry_o | output | A_W+B_W | Carry vector of the redundant product, shifted left, bit 0 always 0 |

## Verification
The hardest cases to reach are the negated-digit corrections. These are the inverted multiple plus the injected +1 at the digit's weight, when several digits are negative at once. They matter most with the most negative multiplicand, where `-2A` wraps through the full result width. Sign-bit patterns such as alternating ones and zeros in the multiplier make every digit negative. An exhaustive sweep over all operand pairs at the default widths drives every digit code into every row position in both representations at once.

// File: rtl/booth_csa_pkg.sv
package booth_csa_pkg;

  // width of the recoded multiplier: room for a non-negative top digit
  // when unsigned, rounded up to an even count of bits
  function automatic int ext_width(input int b_w, input int sgn);
    int base;
    base = (sgn != 0) ? b_w : b_w + 1;
    return base + (base % 2);
  endfunction

  function automatic int digit_count(input int b_w, input int sgn);
    return ext_width(b_w, sgn) / 2;
  endfunction

endpackage

// File: rtl/booth_csa_enc.sv
module booth_csa_enc
  import booth_csa_pkg::*;
#(
  parameter int B_W        = 7,
  parameter int SIGNED_OPS = 1,
  localparam int BX_W      = ext_width(B_W, SIGNED_OPS),
  localparam int NDIG      = digit_count(B_W, SIGNED_OPS)
) (
  input  logic [B_W-1:0]  op_b_i,
  output logic [NDIG-1:0] neg_o,
  output logic [NDIG-1:0] one_o,
  output logic [NDIG-1:0] two_o
);

  logic [BX_W-1:0] b_ext;
  logic [BX_W:0]   b_grp;

  generate
    if (BX_W > B_W) begin : g_ext
      logic fill;
      assign fill  = (SIGNED_OPS != 0) ? op_b_i[B_W-1] : 1'b0;
      assign b_ext = {{(BX_W-B_W){fill}}, op_b_i};
    end else begin : g_noext
      assign b_ext = op_b_i;
    end
  endgenerate

  assign b_grp = {b_ext, 1'b0};

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    logic [2:0] g;
    assign g        = b_grp[2*d+2 -: 3];
    assign one_o[d] = g[1] ^ g[0];
    assign two_o[d] = (g == 3'b011) || (g == 3'b100);
    // 111 is -0: keep it positive so a zero digit injects nothing
    assign neg_o[d] = g[2] & ~(g[1] & g[0]);
  end

endmodule

// File: rtl/booth_csa_ppgen.sv
module booth_csa_ppgen
  import booth_csa_pkg::*;
#(
  parameter int A_W        = 8,
  parameter int B_W        = 7,
  parameter int SIGNED_OPS = 1,
  localparam int W         = A_W + B_W,
  localparam int NDIG      = digit_count(B_W, SIGNED_OPS)
) (
  input  logic [A_W-1:0]  op_a_i,
  input  logic [NDIG-1:0] neg_i,
  input  logic [NDIG-1:0] one_i,
  input  logic [NDIG-1:0] two_i,
  output logic [W-1:0]    rows_o [NDIG],
  output logic [W-1:0]    inj_o
);

  logic [W-1:0] a_ext;
  logic         a_fill;

  assign a_fill = (SIGNED_OPS != 0) ? op_a_i[A_W-1] : 1'b0;
  assign a_ext  = {{B_W{a_fill}}, op_a_i};

  for (genvar d = 0; d < NDIG; d++) begin : g_row
    logic [W-1:0] mag;
    logic [W-1:0] cond;
    always_comb begin
      mag = '0;
      if (one_i[d])      mag = a_ext;
      else if (two_i[d]) mag = a_ext << 1;
      cond = neg_i[d] ? ~mag : mag;
    end
    assign rows_o[d] = cond << (2*d);
  end

  // +1 corrections of negated rows; positions 2d never collide
  always_comb begin
    inj_o = '0;
    for (int d = 0; d < NDIG; d++) inj_o[2*d] = neg_i[d];
  end

endmodule

// File: rtl/booth_csa_tree.sv
module booth_csa_tree #(
  parameter int W    = 15,
  parameter int NROW = 4,
  localparam int NST = (NROW > 1) ? NROW - 1 : 1
) (
  input  logic [W-1:0] rows_i [NROW],
  input  logic [W-1:0] inj_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  logic [W-1:0] s_st [NST+1];
  logic [W-1:0] c_st [NST+1];

  // correction vector seeds the carry rail, saving one adder row
  assign s_st[0] = rows_i[0];
  assign c_st[0] = inj_i;

  for (genvar k = 0; k < NST; k++) begin : g_stage
    logic [W-1:0] x;
    logic [W-1:0] maj;
    if (k + 1 < NROW) begin : g_in
      assign x = rows_i[k+1];
    end else begin : g_pad
      assign x = '0;
    end
    assign s_st[k+1] = s_st[k] ^ c_st[k] ^ x;
    assign maj       = (s_st[k] & c_st[k]) | (s_st[k] & x) | (c_st[k] & x);
    assign c_st[k+1] = {maj[W-2:0], 1'b0};
  end

  assign sum_o   = s_st[NST];
  assign carry_o = c_st[NST];

endmodule

// File: rtl/booth_csa_mul.sv
module booth_csa_mul
  import booth_csa_pkg::*;
#(
  parameter int A_W        = 8,
  parameter int B_W        = 7,
  parameter int SIGNED_OPS = 1,
  localparam int W         = A_W + B_W,
  localparam int NDIG      = digit_count(B_W, SIGNED_OPS)
) (
  input  logic [A_W-1:0] op_a_i,
  input  logic [B_W-1:0] op_b_i,
  output logic [W-1:0]   psum_o,
  output logic [W-1:0]   pcarry_o
);

  logic [NDIG-1:0] dig_neg;
  logic [NDIG-1:0] dig_one;
  logic [NDIG-1:0] dig_two;
  logic [W-1:0]    pp_rows [NDIG];
  logic [W-1:0]    pp_inj;

  booth_csa_enc #(
    .B_W(B_W), .SIGNED_OPS(SIGNED_OPS)
  ) u_enc (
    .op_b_i(op_b_i), .neg_o(dig_neg), .one_o(dig_one), .two_o(dig_two)
  );

  booth_csa_ppgen #(
    .A_W(A_W), .B_W(B_W), .SIGNED_OPS(SIGNED_OPS)
  ) u_ppgen (
    .op_a_i(op_a_i), .neg_i(dig_neg), .one_i(dig_one), .two_i(dig_two),
    .rows_o(pp_rows), .inj_o(pp_inj)
  );

  booth_csa_tree #(
    .W(W), .NROW(NDIG)
  ) u_tree (
    .rows_i(pp_rows), .inj_i(pp_inj), .sum_o(psum_o), .carry_o(pcarry_o)
  );

endmodule

// File: rtl/booth_csa_mul_chk.sv
module booth_csa_mul_chk
  import booth_csa_pkg::*;
#(
  parameter int A_W        = 8,
  parameter int B_W        = 7,
  parameter int SIGNED_OPS = 1,
  localparam int W         = A_W + B_W,
  localparam int NDIG      = digit_count(B_W, SIGNED_OPS)
) (
  input logic [A_W-1:0]  op_a_i,
  input logic [B_W-1:0]  op_b_i,
  input logic [W-1:0]    psum_o,
  input logic [W-1:0]    pcarry_o,
  input logic [NDIG-1:0] dig_neg,
  input logic [NDIG-1:0] dig_one,
  input logic [NDIG-1:0] dig_two
);

  logic [W-1:0] ax, bx, ref_p, tot;

  always_comb begin
    ax    = {{B_W{(SIGNED_OPS != 0) & op_a_i[A_W-1]}}, op_a_i};
    bx    = {{A_W{(SIGNED_OPS != 0) & op_b_i[B_W-1]}}, op_b_i};
    ref_p = ax * bx;
    tot   = psum_o + pcarry_o;
    // R1
    product_sum_chk: assert (tot == ref_p)
      else $error("redundant product %0h != %0h", tot, ref_p);
    // R2
    carry_lsb_chk: assert (pcarry_o[0] == 1'b0)
      else $error("carry bus lsb set");
    for (int d = 0; d < NDIG; d++) begin
      // R4
      digit_sel_chk: assert (!(dig_one[d] && dig_two[d]))
        else $error("digit %0d selects both magnitudes", d);
      // R5
      zero_digit_neg_chk: assert (dig_one[d] || dig_two[d] || !dig_neg[d])
        else $error("digit %0d negates zero", d);
    end
    // R6
    unsigned_top_digit_chk: assert ((SIGNED_OPS != 0) || !dig_neg[NDIG-1])
      else $error("unsigned top digit negative");
  end

endmodule

bind booth_csa_mul booth_csa_mul_chk #(
  .A_W(A_W), .B_W(B_W), .SIGNED_OPS(SIGNED_OPS)
) u_chk (
  .op_a_i(op_a_i), .op_b_i(op_b_i), .psum_o(psum_o), .pcarry_o(pcarry_o),
  .dig_neg(dig_neg), .dig_one(dig_one), .dig_two(dig_two)
);

// File: tb/booth_csa_mul_tb.sv
module booth_csa_mul_tb;
  localparam int A_W = 8;
  localparam int B_W = 7;
  localparam int W   = A_W + B_W;
  localparam int NV  = 10;

  // {op_a, op_b}
  localparam logic [W-1:0] VEC [NV] = '{
    {8'h00, 7'h00}, {8'hFF, 7'h7F}, {8'h80, 7'h40}, {8'h80, 7'h7F},
    {8'h7F, 7'h3F}, {8'h01, 7'h01}, {8'hFF, 7'h01}, {8'h55, 7'h2A},
    {8'hAA, 7'h55}, {8'h7F, 7'h40}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [A_W-1:0] a;
  logic [B_W-1:0] b;
  logic [W-1:0]   s_sum, s_car, u_sum, u_car;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  booth_csa_mul #(.A_W(A_W), .B_W(B_W), .SIGNED_OPS(1)) u_dut (
    .op_a_i(a), .op_b_i(b), .psum_o(s_sum), .pcarry_o(s_car)
  );
  booth_csa_mul #(.A_W(A_W), .B_W(B_W), .SIGNED_OPS(0)) u_dut_u (
    .op_a_i(a), .op_b_i(b), .psum_o(u_sum), .pcarry_o(u_car)
  );

  function automatic logic [W-1:0] ref_mul(input logic [A_W-1:0] x,
                                           input logic [B_W-1:0] y,
                                           input bit sgn);
    logic [W-1:0] xe, ye;
    xe = {{B_W{sgn & x[A_W-1]}}, x};
    ye = {{A_W{sgn & y[B_W-1]}}, y};
    return xe * ye;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [A_W-1:0] x, input logic [B_W-1:0] y);
    @(negedge clk);
    a = x;
    b = y;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0;
    b = '0;
    // table walk: R1, R2, R3 in both representations
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][W-1:B_W], VEC[i][B_W-1:0]);
      chk("R1/R3 signed", s_sum + s_car, ref_mul(a, b, 1'b1));
      chk("R1/R3 unsigned", u_sum + u_car, ref_mul(a, b, 1'b0));
      chk("R2 signed lsb", {{(W-1){1'b0}}, s_car[0]}, '0);
      chk("R2 unsigned lsb", {{(W-1){1'b0}}, u_car[0]}, '0);
    end

    // R7 extremes
    apply(8'h80, 7'h40);
    chk("R7 signed min*min", s_sum + s_car, 15'h2000);
    apply(8'hFF, 7'h7F);
    chk("R7 unsigned all-ones", u_sum + u_car, 15'h7E81);
    chk("R3 signed -1*-1", s_sum + s_car, 15'h0001);
    apply(8'h00, 7'h00);
    chk("R1 zero operands", s_sum + s_car, '0);

    // R6: multiplier with MSB set in unsigned mode stays positive
    apply(8'h01, 7'h7F);
    chk("R6 unsigned top digit", u_sum + u_car, 15'h007F);
    chk("R3 signed 1*-1", s_sum + s_car, 15'h7FFF);

    // R8: new inputs settle with no clock edge in between
    @(negedge clk);
    a = 8'h03; b = 7'h05; #1;
    a = 8'h06; b = 7'h07; #1;
    chk("R8 no state", s_sum + s_car, 15'd42);

    // exhaustive sweep: every digit code in every row (R1, R2, R4, R5, R6)
    begin
      int bad = 0;
      for (int x = 0; x < (1 << A_W); x++) begin
        for (int y = 0; y < (1 << B_W); y++) begin
          apply(x[A_W-1:0], y[B_W-1:0]);
          if ((s_sum + s_car) !== ref_mul(a, b, 1'b1) || s_car[0] !== 1'b0 ||
              (u_sum + u_car) !== ref_mul(a, b, 1'b0) || u_car[0] !== 1'b0) begin
            if (bad < 4)
              $display("FAIL R1/R4/R5 sweep a=%h b=%h actual=%h/%h expected=%h/%h",
                       a, b, s_sum + s_car, u_sum + u_car,
                       ref_mul(a, b, 1'b1), ref_mul(a, b, 1'b0));
            bad++;
          end
        end
      end
      checks++;
      if (bad != 0) errors++;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule